// File: doc/BRIEF.md
# Registered I/O Cell Bank with Early-Clock Input Capture

This block models the registered paths of a bank of programmable I/O cells. On the way in, each cell can first hold the pad value in a capture latch. That latch is open while an early clock is high. A global clock then moves the held value into the input storage element. If the capture stage is switched off, the storage element samples the pad directly. Configuration makes the input storage element either an edge-triggered register or a level-sensitive latch.

On the way out, each cell registers its output data on the rising edge of an output clock. A small pad multiplexer then chooses what drives the pad. It can pass the output register straight through. It can use the output clock level as a select, so that the output data and the cell's clock-enable line take turns on one pad. It can also AND those two signals together for a fast pin-to-pin path.

The input and output storage elements of a cell share one clock-enable line. Static configuration pins decide which element that line gates. An element that is not gated is always enabled. All pins are plain levels sampled at pad timing, with no handshake.

Top module: `iocell_fastcap`

## Requirements
- R1: While `grst` is high, every input storage element, capture latch and output register is forced to INIT (default 0) at once, without waiting for a clock edge; `iq` and, in direct mode, `pad_out` read INIT.
- R2: With `ce_route[0]`=1, the input storage element of cell i is gated by `ce[i]`; with `ce_route[0]`=0 it is always enabled, whatever `ce[i]` is.
- R3: With `ce_route[1]`=1, the output register of cell i is gated by `ce[i]`; with `ce_route[1]`=0 it is always enabled.
- R4: Clock enable is active high: a gated element loads new data only while its `ce[i]` is 1 and keeps its value while `ce[i]` is 0. No clock is gated.
- R5: With `fc_en`=1, the capture latch follows `pad_in` while `early_clk` is high and holds while it is low. The input element loads the latch value, so a pad change that arrives after `early_clk` falls but before `gclk` rises shows up in `iq` one global cycle later.
- R6: With `fc_en`=0, the input element takes `pad_in` directly: in register mode at the rising edge of `gclk`, with `iq` unchanged between edges.
- R7: With `in_latch`=1, the input element is transparent while `gclk` is high and it is enabled, and holds while `gclk` is low. With `in_latch`=0 it is a rising-edge register on `gclk`.
- R8: The output register of cell i loads `odata[i]` at the rising edge of `out_clk`.
- R9: `pad_mode` 2'b00, and the spare code 2'b11, drive `pad_out` from the output register.
- R10: `pad_mode` 2'b01 drives `pad_out` from the output register while `out_clk` is high and from `ce` while `out_clk` is low.
- R11: `pad_mode` 2'b10 drives `pad_out` with the bitwise AND of the output register and `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grst | input | 1 | Global asynchronous reset, active high |
| gclk | input | 1 | Global clock for the input storage element |
| early_clk | input | 1 | Early clock; capture latch open while high |
| out_clk | input | 1 | Output register clock and pad select |
| ce_route | input | 2 | Bit 0 gates the input element, bit 1 gates the output register |
| fc_en | input | 1 | Enable the early-clock capture latch |
| in_latch | input | 1 | 1: input element is a latch, 0: a register |
| pad_mode | input | 2 | Pad multiplexer mode (00 direct, 01 clock select, 10 AND, 11 direct) |
| pad_in | input | WIDTH | Pad input levels, one per cell |
| ce | input | WIDTH | Shared clock enable, one per cell |
| odata | input | WIDTH | Output data, one per cell |
| iq | output | WIDTH | Input storage element outputs |
| pad_out | output | WIDTH | Pad drive levels |

## Verification
The hardest case to reach from the ports is a pad change that falls in the short gap after the early clock has closed the capture latch but before the global clock rises. Only that timing shows the one-cycle difference between capture on and capture off. The bench gives the early clock and the global clock fixed, offset phases. It places the pad change half a nanosecond into that gap, then checks `iq` on both sides of the next two global edges. A second delicate case is the latch-mode input element. Here pad changes are placed both inside and outside the high phase of the global clock, so that transparency and hold are each observed directly.

// File: rtl/iocell_pkg.sv
package iocell_pkg;
  typedef enum logic [1:0] {
    PAD_DIRECT = 2'b00,
    PAD_CLKSEL = 2'b01,
    PAD_AND    = 2'b10,
    PAD_SPARE  = 2'b11
  } pad_mode_e;

  localparam int CE_BIT_IN  = 0;
  localparam int CE_BIT_OUT = 1;
endpackage

// File: rtl/iocell_in_path.sv
module iocell_in_path #(
  parameter logic INIT = 1'b0
) (
  input  logic grst,
  input  logic early_clk,
  input  logic gclk,
  input  logic fc_en,
  input  logic in_latch,
  input  logic en,
  input  logic pad_i,
  output logic fc_q,
  output logic iq
);
  logic cap_q;
  logic stage_d;
  logic reg_q;
  logic lat_q;

  // early-clock capture latch
  always_latch begin
    if (grst)           cap_q <= INIT;
    else if (early_clk) cap_q <= pad_i;
  end

  assign stage_d = fc_en ? cap_q : pad_i;

  // edge-triggered variant
  always_ff @(posedge gclk or posedge grst) begin
    if (grst)    reg_q <= INIT;
    else if (en) reg_q <= stage_d;
  end

  // level-sensitive variant
  always_latch begin
    if (grst)            lat_q <= INIT;
    else if (gclk && en) lat_q <= stage_d;
  end

  assign fc_q = cap_q;
  assign iq   = in_latch ? lat_q : reg_q;
endmodule

// File: rtl/iocell_out_path.sv
module iocell_out_path #(
  parameter logic INIT = 1'b0
) (
  input  logic grst,
  input  logic out_clk,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge out_clk or posedge grst) begin
    if (grst)    q <= INIT;
    else if (en) q <= d;
  end
endmodule

// File: rtl/iocell_pad_mux.sv
module iocell_pad_mux
  import iocell_pkg::*;
(
  input  pad_mode_e mode,
  input  logic      sel_clk,
  input  logic      oq,
  input  logic      ce,
  output logic      pad
);
  always_comb begin
    unique case (mode)
      PAD_CLKSEL: pad = sel_clk ? oq : ce;
      PAD_AND:    pad = oq & ce;
      default:    pad = oq;
    endcase
  end
endmodule

// File: rtl/iocell_fastcap.sv
module iocell_fastcap
  import iocell_pkg::*;
#(
  parameter int   WIDTH = 4,
  parameter logic INIT  = 1'b0
) (
  input  logic             grst,
  input  logic             gclk,
  input  logic             early_clk,
  input  logic             out_clk,
  input  logic [1:0]       ce_route,
  input  logic             fc_en,
  input  logic             in_latch,
  input  logic [1:0]       pad_mode,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] ce,
  input  logic [WIDTH-1:0] odata,
  output logic [WIDTH-1:0] iq,
  output logic [WIDTH-1:0] pad_out
);
  localparam int LAST = WIDTH - 1;

  pad_mode_e        mode_q;
  logic [LAST:0]    fc_q;
  logic [LAST:0]    o_q;
  logic [LAST:0]    in_en;
  logic [LAST:0]    out_en;

  assign mode_q = pad_mode_e'(pad_mode);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign in_en[i]  = !ce_route[CE_BIT_IN]  || ce[i];
    assign out_en[i] = !ce_route[CE_BIT_OUT] || ce[i];

    iocell_in_path #(.INIT(INIT)) in_i (
      .grst      (grst),
      .early_clk (early_clk),
      .gclk      (gclk),
      .fc_en     (fc_en),
      .in_latch  (in_latch),
      .en        (in_en[i]),
      .pad_i     (pad_in[i]),
      .fc_q      (fc_q[i]),
      .iq        (iq[i])
    );

    iocell_out_path #(.INIT(INIT)) out_i (
      .grst    (grst),
      .out_clk (out_clk),
      .en      (out_en[i]),
      .d       (odata[i]),
      .q       (o_q[i])
    );

    iocell_pad_mux mux_i (
      .mode    (mode_q),
      .sel_clk (out_clk),
      .oq      (o_q[i]),
      .ce      (ce[i]),
      .pad     (pad_out[i])
    );
  end
endmodule

// File: rtl/iocell_fastcap_chk.sv
module iocell_fastcap_chk #(
  parameter int   WIDTH = 4,
  parameter logic INIT  = 1'b0
) (
  input logic             grst,
  input logic             gclk,
  input logic             out_clk,
  input logic [1:0]       ce_route,
  input logic             fc_en,
  input logic             in_latch,
  input logic [1:0]       pad_mode,
  input logic [WIDTH-1:0] ce,
  input logic [WIDTH-1:0] odata,
  input logic [WIDTH-1:0] fc_q,
  input logic [WIDTH-1:0] o_q,
  input logic [WIDTH-1:0] iq,
  input logic [WIDTH-1:0] pad_out
);
  always @(posedge gclk) begin
    if (grst) begin
      // R1
      reset_clear_chk: assert (iq == {WIDTH{INIT}} && o_q == {WIDTH{INIT}} && fc_q == {WIDTH{INIT}});
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    // R4
    in_hold_chk: assert property (@(posedge gclk) disable iff (grst)
      (!in_latch && ce_route[0] && !ce[i]) |=> ($stable(iq[i]) || in_latch));

    // R5
    fast_cap_chk: assert property (@(posedge gclk) disable iff (grst)
      (fc_en && !in_latch && (!ce_route[0] || ce[i])) |=> (iq[i] == $past(fc_q[i]) || in_latch));

    // R8
    out_load_chk: assert property (@(posedge out_clk) disable iff (grst)
      (!ce_route[1] || ce[i]) |=> (o_q[i] == $past(odata[i])));
  end

  // R11
  and_mask_chk: assert property (@(negedge gclk) disable iff (grst)
    (pad_mode == 2'b10) |-> ((pad_out & ~ce) == '0));

  // R10
  clksel_high_chk: assert property (@(negedge out_clk) disable iff (grst)
    (pad_mode == 2'b01) |-> (pad_out == o_q));
endmodule

bind iocell_fastcap iocell_fastcap_chk #(.WIDTH(WIDTH), .INIT(INIT)) chk_i (
  .grst     (grst),
  .gclk     (gclk),
  .out_clk  (out_clk),
  .ce_route (ce_route),
  .fc_en    (fc_en),
  .in_latch (in_latch),
  .pad_mode (pad_mode),
  .ce       (ce),
  .odata    (odata),
  .fc_q     (fc_q),
  .o_q      (o_q),
  .iq       (iq),
  .pad_out  (pad_out)
);

// File: tb/iocell_fastcap_tb_top.sv
`timescale 1ns/100ps
module iocell_fastcap_tb_top;
  localparam int W = 4;

  logic         grst;
  logic         gclk;
  logic         early_clk;
  logic         out_clk;
  logic [1:0]   ce_route;
  logic         fc_en;
  logic         in_latch;
  logic [1:0]   pad_mode;
  logic [W-1:0] pad_in;
  logic [W-1:0] ce;
  logic [W-1:0] odata;
  logic [W-1:0] iq;
  logic [W-1:0] pad_out;

  int n_vec;
  int n_bad;
  bit done;

  iocell_fastcap #(.WIDTH(W)) dut_i (
    .grst(grst), .gclk(gclk), .early_clk(early_clk), .out_clk(out_clk),
    .ce_route(ce_route), .fc_en(fc_en), .in_latch(in_latch), .pad_mode(pad_mode),
    .pad_in(pad_in), .ce(ce), .odata(odata), .iq(iq), .pad_out(pad_out)
  );

  // 8 ns period: early_clk high 0..3, gclk/out_clk high 4..8
  initial begin
    gclk = 1'b0; early_clk = 1'b0; out_clk = 1'b0;
    forever begin
      early_clk = 1'b1;
      #3 early_clk = 1'b0;
      #1 gclk = 1'b1; out_clk = 1'b1;
      #4 gclk = 1'b0; out_clk = 1'b0;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // lands 1 ns after a gclk rising edge
  task automatic step();
    @(posedge gclk);
    #1;
  endtask

  task automatic t_reset_start();
    pad_in = 4'hF; odata = 4'hF; ce = 4'hF;
    step();
    check("R1 iq under reset", iq, 4'h0);
    check("R1 pad under reset", pad_out, 4'h0);
    grst = 1'b0;
  endtask

  task automatic t_direct();
    fc_en = 0; in_latch = 0; ce_route = 2'b00; ce = 4'h0;
    pad_in = 4'h3;
    step();
    check("R6 direct load", iq, 4'h3);
    pad_in = 4'hA;
    #4 check("R6 no change between edges", iq, 4'h3);
    #2.5 pad_in = 4'hC;
    step();
    check("R6 late change taken at edge", iq, 4'hC);
  endtask

  task automatic t_fast();
    fc_en = 1; pad_in = 4'h5;
    step(); step();
    check("R5 settled", iq, 4'h5);
    pad_in = 4'h9;
    #6.5 pad_in = 4'h6;
    step();
    check("R5 late change held back", iq, 4'h9);
    step();
    check("R5 late change next cycle", iq, 4'h6);
    fc_en = 0;
  endtask

  task automatic t_ce_in();
    ce_route = 2'b01; ce = 4'h0; pad_in = 4'hF;
    step();
    check("R4 ce low holds input", iq, 4'h6);
    ce = 4'h5;
    step();
    check("R2 per-bit enable", iq, 4'h7);
    ce_route = 2'b00; ce = 4'h0; pad_in = 4'h0;
    step();
    check("R2 route off ignores ce", iq, 4'h0);
  endtask

  task automatic t_latch();
    in_latch = 1; ce_route = 2'b00; ce = 4'h0;
    pad_in = 4'hB;
    #1 check("R7 transparent while gclk high", iq, 4'hB);
    #3 pad_in = 4'h4;
    #1 check("R7 holds while gclk low", iq, 4'hB);
    #3 check("R7 follows after gclk rises", iq, 4'h4);
    ce_route = 2'b01; pad_in = 4'h1;
    #1 check("R4 latch disabled holds", iq, 4'h4);
    in_latch = 0; ce_route = 2'b00;
  endtask

  task automatic t_out();
    pad_mode = 2'b00; ce_route = 2'b00; ce = 4'h0;
    step();
    odata = 4'h3;
    step();
    check("R8 output register load", pad_out, 4'h3);
    odata = 4'hC;
    #4 check("R9 pad holds until out_clk edge", pad_out, 4'h3);
    step();
    check("R8 next load", pad_out, 4'hC);
    ce_route = 2'b10; ce = 4'h0; odata = 4'h5;
    step();
    check("R3 output gated hold", pad_out, 4'hC);
    ce = 4'h3;
    step();
    check("R3 per-bit output enable", pad_out, 4'hD);
    ce_route = 2'b00; ce = 4'h0;
    step();
    check("R3 route off loads", pad_out, 4'h5);
  endtask

  task automatic t_sel();
    pad_mode = 2'b01; ce = 4'hA;
    #1 check("R10 out_clk high shows data", pad_out, 4'h5);
    #4 check("R10 out_clk low shows ce", pad_out, 4'hA);
    ce = 4'h6;
    #1 check("R10 ce follows while low", pad_out, 4'h6);
  endtask

  task automatic t_and();
    step();
    pad_mode = 2'b10; ce = 4'h6;
    #1 check("R11 and mode", pad_out, 4'h4);
    ce = 4'hF;
    #1 check("R11 and all ones", pad_out, 4'h5);
    ce = 4'h0;
    #1 check("R11 and zero", pad_out, 4'h0);
    pad_mode = 2'b11;
    #1 check("R9 spare code direct", pad_out, 4'h5);
  endtask

  task automatic t_reset_mid();
    pad_mode = 2'b00; odata = 4'hF; pad_in = 4'hF;
    step(); step();
    check("R1 pre-reset iq", iq, 4'hF);
    grst = 1'b1;
    #1 check("R1 async iq clear", iq, 4'h0);
    check("R1 async pad clear", pad_out, 4'h0);
    step();
    grst = 1'b0;
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    grst = 1'b1; ce_route = 2'b00; fc_en = 0; in_latch = 0;
    pad_mode = 2'b00; pad_in = '0; ce = '0; odata = '0;
    t_reset_start();
    t_direct();
    t_fast();
    t_ce_in();
    t_latch();
    t_out();
    t_sel();
    t_and();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule